// File: doc/BRIEF.md
# Table-Driven DMA Slot Scheduler

This block chooses which DMA channel, and in which direction, receives each transfer slot. Software fills a table of byte-wide entries through a small memory-mapped read/write port. Each entry names a channel and says whether the slot is for receive or transmit. Four entries are packed into each 32-bit table word.

A control word turns the scheduler on and sets the index of the last entry in use. While the scheduler is enabled, it walks the table from entry 0 up to that index and then starts again at entry 0. For each entry it presents one grant to the channel engines and holds it until the engines accept it with a valid/ready handshake.

The usual software sequence is: clear the control word, rewrite the table, then write the last index together with the enable bit. With 30 channels, each channel has one transmit slot and one receive slot, so the last index is 59.

Top module: `dma_slot_sched`

## Requirements
- R1: After reset, no grant is valid, the control word reads as 0, and the walk starts at entry 0.
- R2: The control word is at byte offset 0x000. Bit 31 is the enable bit and bits 7:0 hold the last-entry index. A read returns the written enable bit and index, and every other bit reads as 0.
- R3: Table word x (0 to 63) is at byte offset 0x800 + 4*x, and reading it returns the last value written. A write to any address that is neither the control word nor a table word changes nothing, and a read of such an address returns 0.
- R4: Entry k sits in table word k/4, in byte lane k%4, with entry 0 in bits 7:0. Within an entry, bits 6:0 give the channel and bit 7 set means receive (0 means transmit). A grant carries exactly these values.
- R5: While enabled, grants follow the table order 0, 1, ..., last and then wrap back to entry 0.
- R6: While enabled, a valid grant that has not been accepted keeps its valid, channel and direction unchanged.
- R7: The walk moves to the next entry only when a grant is accepted (valid and ready high together).
- R8: Clearing the enable bit withdraws the grant by the following clock. The next enable starts again at entry 0.
- R9: If the last index is lowered below the current entry, the next accepted grant wraps the walk to entry 0.
- R10: Read data and its valid strobe appear exactly one clock after the read request, and the strobe is low at all other times.
- R11: With the last index set to 0, every grant comes from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid when reg_rvalid is high |
| reg_rvalid | output | 1 | Read data strobe |
| gnt_valid | output | 1 | A grant is being offered |
| gnt_chan | output | 7 | Channel of the offered grant |
| gnt_rx | output | 1 | 1 for a receive slot, 0 for a transmit slot |
| gnt_ready | input | 1 | The channel engines accept the grant |

## Verification
The bound checker tests these properties on every cycle:
- A grant stays stable while it waits for ready.
- The grant is withdrawn after the enable bit is cleared.
- The entry index stays fixed when there is no handshake, and it wraps to 0 after the last entry.
- Reset behaves as required.
- Read data arrives with one clock of latency.

Other behaviour depends on table contents, so only the bench scenarios can show it:
- The actual order of channels and directions across the table.
- The byte-lane packing of entries.
- Address decode, including writes to unmapped addresses that must not alias into the table.
- What happens when the last index is lowered during a run.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int ENTRY_W = 8;

  typedef struct packed {
    logic       rx;
    logic [6:0] chan;
  } sched_entry_t;
endpackage

// File: rtl/sched_table_mem.sv
module sched_table_mem #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  parameter int AW     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     a_addr,
  output logic [DATA_W-1:0] a_q,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_q
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/sched_regs.sv
module sched_regs #(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 32,
  parameter int              WIDX_W   = 6,
  parameter int              IDX_W    = 8,
  parameter int              EN_BIT   = 31,
  parameter logic [ADDR_W-1:0] TBL_BASE = 12'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              en_q,
  output logic [IDX_W-1:0]  last_q,
  output logic              tbl_we,
  output logic [WIDX_W-1:0] tbl_idx,
  input  logic [DATA_W-1:0] tbl_q
);
  localparam int HI = WIDX_W + 2;

  logic hit_ctrl, hit_tbl;
  logic sel_tbl_q;
  logic [DATA_W-1:0] ctrl_rd_q;

  assign hit_ctrl = (addr == '0);
  assign hit_tbl  = (addr[ADDR_W-1:HI] == TBL_BASE[ADDR_W-1:HI]);
  assign tbl_idx  = addr[HI-1:2];
  assign tbl_we   = wr && hit_tbl;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      last_q    <= '0;
      rvalid    <= 1'b0;
      sel_tbl_q <= 1'b0;
      ctrl_rd_q <= '0;
    end else begin
      if (wr && hit_ctrl) begin
        en_q   <= wdata[EN_BIT];
        last_q <= wdata[IDX_W-1:0];
      end
      rvalid    <= rd;
      sel_tbl_q <= rd && hit_tbl;
      ctrl_rd_q <= '0;
      if (rd && hit_ctrl) begin
        ctrl_rd_q[EN_BIT]     <= en_q;
        ctrl_rd_q[IDX_W-1:0]  <= last_q;
      end
    end
  end

  assign rdata = sel_tbl_q ? tbl_q : ctrl_rd_q;
endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import sched_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int LANE_W = 2,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [IDX_W-1:0]        last,
  input  logic [DATA_W-1:0]       word,
  output logic [IDX_W-LANE_W-1:0] word_idx,
  output logic [IDX_W-1:0]        cur_idx,
  output logic                    gnt_valid,
  output logic [6:0]              gnt_chan,
  output logic                    gnt_rx,
  input  logic                    gnt_ready
);
  logic [IDX_W-1:0] ptr;
  logic pend;
  logic [LANES-1:0][ENTRY_W-1:0] lanes;
  sched_entry_t ent;

  assign lanes    = word;
  assign ent      = sched_entry_t'(lanes[ptr[LANE_W-1:0]]);
  assign word_idx = ptr[IDX_W-1:LANE_W];
  assign cur_idx  = ptr;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ptr       <= '0;
      pend      <= 1'b0;
      gnt_valid <= 1'b0;
      if (rst) begin
        gnt_chan <= '0;
        gnt_rx   <= 1'b0;
      end
    end else if (gnt_valid && gnt_ready) begin
      gnt_valid <= 1'b0;
      ptr       <= (ptr >= last) ? '0 : ptr + 1'b1;
    end else if (pend) begin
      pend      <= 1'b0;
      gnt_valid <= 1'b1;
      gnt_chan  <= ent.chan;
      gnt_rx    <= ent.rx;
    end else if (!gnt_valid) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_slot_sched.sv
module dma_slot_sched #(
  parameter int              ADDR_W    = 12,
  parameter int              DATA_W    = 32,
  parameter int              TBL_WORDS = 64,
  parameter int              EN_BIT    = 31,
  parameter logic [ADDR_W-1:0] TBL_BASE  = 12'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              gnt_valid,
  output logic [6:0]        gnt_chan,
  output logic              gnt_rx,
  input  logic              gnt_ready
);
  localparam int LANES  = DATA_W / sched_pkg::ENTRY_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int WIDX_W = $clog2(TBL_WORDS);
  localparam int IDX_W  = WIDX_W + LANE_W;

  logic              en_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  cur_idx;
  logic              tbl_we;
  logic [WIDX_W-1:0] tbl_idx, walk_idx;
  logic [DATA_W-1:0] tbl_a_q, tbl_b_q;

  sched_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDX_W(WIDX_W), .IDX_W(IDX_W),
    .EN_BIT(EN_BIT), .TBL_BASE(TBL_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .rvalid(reg_rvalid),
    .en_q(en_q), .last_q(last_q), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_q(tbl_a_q)
  );

  sched_table_mem #(.WORDS(TBL_WORDS), .DATA_W(DATA_W), .AW(WIDX_W)) u_mem (
    .clk(clk), .we(tbl_we), .waddr(tbl_idx), .wdata(reg_wdata),
    .a_addr(tbl_idx), .a_q(tbl_a_q), .b_addr(walk_idx), .b_q(tbl_b_q)
  );

  sched_walker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LANE_W(LANE_W), .LANES(LANES)) u_walk (
    .clk(clk), .rst(rst), .en(en_q), .last(last_q), .word(tbl_b_q),
    .word_idx(walk_idx), .cur_idx(cur_idx), .gnt_valid(gnt_valid),
    .gnt_chan(gnt_chan), .gnt_rx(gnt_rx), .gnt_ready(gnt_ready)
  );
endmodule

// File: rtl/dma_slot_sched_chk.sv
module dma_slot_sched_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic [IDX_W-1:0] last_q,
  input logic [IDX_W-1:0] cur_idx,
  input logic             gnt_valid,
  input logic             gnt_ready,
  input logic [6:0]       gnt_chan,
  input logic             gnt_rx,
  input logic             reg_rd,
  input logic             reg_rvalid
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> !gnt_valid && cur_idx == '0);

  a_r6_grant_hold: assert property (@(posedge clk) disable iff (rst)
    en_q && gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_chan) && $stable(gnt_rx));

  a_r7_idx_hold: assert property (@(posedge clk) disable iff (rst)
    en_q && !(gnt_valid && gnt_ready) |=> $stable(cur_idx));

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    en_q && gnt_valid && gnt_ready && cur_idx >= last_q |=> cur_idx == '0);

  a_r8_disable: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !gnt_valid && cur_idx == '0);

  a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);
endmodule

bind dma_slot_sched dma_slot_sched_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .last_q(last_q), .cur_idx(cur_idx),
  .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_chan(gnt_chan),
  .gnt_rx(gnt_rx), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid)
);

// File: tb/dma_slot_sched_tb_top.sv
module dma_slot_sched_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid, gnt_valid, gnt_rx;
  logic [6:0] gnt_chan;
  logic gnt_ready = 1'b0;

  int checks = 0, errors = 0;
  logic [31:0] tbl_m [64];
  int m_idx = 0;
  int m_last = 0;

  always #5 clk = ~clk;

  dma_slot_sched dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .gnt_rx(gnt_rx), .gnt_ready(gnt_ready)
  );

  function automatic logic [7:0] entry_of(int k);
    return tbl_m[k/4][8*(k%4) +: 8];
  endfunction

  function automatic int next_idx(int k, int last);
    return (k >= last) ? 0 : k + 1;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rvalid === 1'b1, "R10 rvalid", {31'd0, reg_rvalid}, 32'd1);
    d = reg_rdata;
  endtask

  task automatic set_ctrl(bit en, int last);
    reg_write(12'h000, {en, 23'd0, 8'(last)});
    m_last = last;
    if (!en) m_idx = 0;
  endtask

  task automatic load_word(int x, logic [31:0] d);
    reg_write(12'h800 + 12'(4 * x), d);
    tbl_m[x] = d;
  endtask

  task automatic run_grants(int n, int pct, string req);
    int got = 0;
    int cyc = 0;
    bit hold = 0;
    logic [6:0] pc;
    logic pr;
    while (got < n && cyc < n * 40) begin
      bit rdy;
      logic [7:0] e;
      @(negedge clk);
      cyc++;
      if (hold)
        check(gnt_valid && gnt_chan == pc && gnt_rx == pr, "R6 hold",
              {24'd0, gnt_valid, gnt_chan}, {24'd0, 1'b1, pc});
      rdy = ($urandom % 100) < pct;
      gnt_ready = rdy;
      if (gnt_valid && rdy) begin
        e = entry_of(m_idx);
        check(gnt_chan == e[6:0] && gnt_rx == e[7], req,
              {24'd0, gnt_rx, gnt_chan}, {24'd0, e});
        m_idx = next_idx(m_idx, m_last);
        got++;
      end
      hold = gnt_valid && !rdy;
      pc = gnt_chan;
      pr = gnt_rx;
    end
    @(negedge clk);
    gnt_ready = 1'b0;
    check(got == n, "R5 grant count", got, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(gnt_valid === 1'b0, "R1 no grant", {31'd0, gnt_valid}, 0);
    reg_read(12'h000, d);
    check(d == 0, "R1 ctrl", d, 0);

    // R3 table readback and decode
    for (int x = 0; x < 64; x++) load_word(x, $urandom);
    for (int x = 0; x < 64; x += 7) begin
      reg_read(12'h800 + 12'(4 * x), d);
      check(d == tbl_m[x], "R3 table readback", d, tbl_m[x]);
    end
    reg_write(12'h900, 32'hDEAD_BEEF);
    reg_write(12'h400, 32'hCAFE_F00D);
    reg_read(12'h800, d);
    check(d == tbl_m[0], "R3 unmapped write ignored", d, tbl_m[0]);
    reg_read(12'h900, d);
    check(d == 0, "R3 unmapped read", d, 0);

    // R2 control word fields
    reg_write(12'h000, 32'hFFFF_FFFF);
    reg_read(12'h000, d);
    check(d == 32'h8000_00FF, "R2 ctrl mask", d, 32'h8000_00FF);
    set_ctrl(0, 0);
    reg_read(12'h000, d);
    check(d == 0, "R2 ctrl cleared", d, 0);
    @(negedge clk);
    check(!gnt_valid, "R8 off", {31'd0, gnt_valid}, 0);

    // R4/R5: paired pattern for 30 channels, ordered walk with wrap
    for (int w = 0; w < 30; w++) begin
      int ch = 2 * (w % 15) + (w / 15) * 0;
      ch = (w * 2) % 30;
      load_word(w, {1'b1, 7'(ch + 1), 1'b0, 7'(ch + 1), 1'b1, 7'(ch), 1'b0, 7'(ch)});
    end
    set_ctrl(1, 59);
    run_grants(150, 60, "R5 order");

    // R8 disable withdraws and restart at 0
    set_ctrl(0, 59);
    @(negedge clk);
    check(!gnt_valid, "R8 withdrawn", {31'd0, gnt_valid}, 0);
    set_ctrl(1, 5);
    run_grants(14, 100, "R8 restart");

    // R9 lower last below current entry
    set_ctrl(0, 0);
    set_ctrl(1, 20);
    run_grants(15, 70, "R9 pre");
    set_ctrl(1, 3);
    run_grants(10, 70, "R9 wrap");

    // R11 single entry
    set_ctrl(0, 0);
    set_ctrl(1, 0);
    run_grants(8, 50, "R11 single");

    // R4 random tables and random last index
    for (int t = 0; t < 4; t++) begin
      set_ctrl(0, 0);
      for (int x = 0; x < 64; x++) load_word(x, $urandom);
      set_ctrl(1, $urandom % 256);
      run_grants(40 + $urandom % 40, 20 + $urandom % 80, "R4 lanes");
    end
    set_ctrl(0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule